// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects a set of level-sensitive interrupt request lines and turns them into a single request toward a processor. Along with that request it supplies a 32-bit handler address, taken from a per-source register, belonging to the most urgent source that is asserted, enabled and above the priority currently being serviced. Priority is fixed: the source with the lower index always wins.

The processor accepts the address by pulsing an acknowledge. The controller then records the serviced source index as the new in-service level on an internal stack. Only sources of strictly higher priority, meaning a lower index, can raise a new request while that level is active. Interrupts can therefore be re-enabled inside a handler without first silencing the source. When a handler finishes, a write to the end-of-service address pops the stack and restores the previous threshold.

Software configures the block through a simple write port of address, data and strobe.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset `cpu_irq` is low and every source is disabled, so an asserted `irq_src` line raises no request until it is enabled.
- R2: A source whose enable bit is 0 never causes `cpu_irq` to rise, whatever its request line does.
- R3: When an enabled, eligible source is asserted while no request is outstanding, `cpu_irq` rises on the next clock edge. At that edge `cpu_vec` carries the vector register of that source.
- R4: When several eligible sources are asserted together, the one with the lowest index is presented.
- R5: While `cpu_irq` is high and `cpu_ack` is low, `cpu_irq` and `cpu_vec` hold their values. This is true even if a higher-priority source asserts or the serviced source drops.
- R6: With `cpu_irq` high, a high `cpu_ack` at a clock edge drops `cpu_irq` at that edge. The presented source index becomes the current in-service level.
- R7: While a level L is in service, only sources with index strictly less than L can request. The source at L and all sources with a larger index are held off, even when asserted and enabled.
- R8: A write to address NSRC+1 (17 by default) is an end-of-service write and pops one in-service level, restoring the threshold that applied before it. An end-of-service write with no level in service has no effect.
- R9: Address i (0 to NSRC-1) writes the vector register of source i. Address NSRC (16 by default) writes the enable mask, where data bit i set to 1 enables source i. Writes to any other address change nothing.
- R10: `cpu_ack` while `cpu_irq` is low is ignored and leaves the in-service level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | NSRC | Level request per source, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration write address |
| cfg_wdata | input | VEC_W | Configuration write data |
| cpu_irq | output | 1 | Combined request toward the processor |
| cpu_vec | output | VEC_W | Handler address of the presented source |
| cpu_ack | input | 1 | Processor accepts the presented address |

## Verification
The hardest state to reach is a three-deep nest in which a still-asserted lower-priority source must stay hidden. A second hard case is a higher-priority source that arrives in the middle of an open handshake. The stimulus builds the nest one level at a time: it acknowledges source 3, then 1, then 0, and raises source 0 while the request for source 1 is still unacknowledged. It then unwinds the nest with end-of-service writes and checks after each pop that the blocked sources reappear only once the threshold allows them. A spurious acknowledge and a surplus end-of-service write on an empty stack are then shown harmless, because a later request still gets through.

// File: rtl/irq_vec_pkg.sv
// Package: shared types for the vectored interrupt controller.
// Assumes: nothing beyond the standard language.
package irq_vec_pkg;

    // Handshake state toward the processor.
    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_REQ  = 1'b1
    } hs_state_t;

endpackage

// File: rtl/irqv_regfile.sv
// Module: irqv_regfile
// Holds one handler address per source and the source enable mask.
// Decodes the end-of-service address into a single-cycle pulse.
// Assumes: NSRC <= VEC_W, so that the enable mask fits in one data word.
module irqv_regfile #(
    parameter int NSRC   = 16,
    parameter int VEC_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [VEC_W-1:0]      wdata,
    output logic [NSRC*VEC_W-1:0] vec_flat,
    output logic [NSRC-1:0]       src_en,
    output logic                  eos_pulse
);
    localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(NSRC);
    localparam logic [ADDR_W-1:0] EOS_ADDR = ADDR_W'(NSRC + 1);

    // One vector register per source.
    for (genvar g = 0; g < NSRC; g++) begin : g_vec
        logic [VEC_W-1:0] vec_q;

        // Purpose: load the vector register on a write to its own address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_q <= '0;
            end else if (we && addr == ADDR_W'(g)) begin
                vec_q <= wdata;
            end
        end

        assign vec_flat[g*VEC_W +: VEC_W] = vec_q;
    end

    // Purpose: enable mask register; it clears to all-disabled on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_en <= '0;
        end else if (we && addr == EN_ADDR) begin
            src_en <= wdata[NSRC-1:0];
        end
    end

    // Purpose: an end-of-service write turns into a pop request.
    always_comb begin
        eos_pulse = we && (addr == EOS_ADDR);
    end

endmodule

// File: rtl/irqv_select.sv
// Module: irqv_select
// Fixed-priority selection: finds the lowest-index source that is asserted,
// enabled and strictly below the current in-service level.
// Assumes: level equals NSRC when nothing is in service.
module irqv_select #(
    parameter int NSRC  = 16,
    parameter int IDX_W = 4,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  req,
    input  logic [NSRC-1:0]  enable,
    input  logic [LVL_W-1:0] level,
    output logic             found,
    output logic [IDX_W-1:0] winner
);
    logic [NSRC-1:0] eligible;

    // Purpose: qualify each source by its enable bit and by the threshold.
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            eligible[i] = req[i] && enable[i] && (LVL_W'(i) < level);
        end
    end

    // Purpose: scan from the lowest priority upward so the lowest index wins.
    always_comb begin
        found  = 1'b0;
        winner = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                found  = 1'b1;
                winner = IDX_W'(i);
            end
        end
    end

    // The chosen source must be requesting and enabled.
    assert_winner_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (req[winner] && enable[winner]));

    // The chosen source must lie strictly above the in-service level.
    assert_winner_above_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ({1'b0, winner} < level));

endmodule

// File: rtl/irqv_level_stack.sv
// Module: irqv_level_stack
// Stack of in-service source indices.
// A push records a serviced level and a pop restores the one below it.
// Assumes: pushes only ever carry an index below the current top, so NSRC
// entries are always enough.
module irqv_level_stack #(
    parameter int NSRC  = 16,
    parameter int IDX_W = 4,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             pop,
    output logic [LVL_W-1:0] cur_level
);
    logic [IDX_W-1:0] slot [NSRC];
    logic [LVL_W-1:0] sp;
    logic [IDX_W-1:0] top_ptr;
    logic [IDX_W-1:0] wr_ptr;

    // Purpose: point at the top entry and at the next free entry.
    always_comb begin
        top_ptr = IDX_W'(sp - LVL_W'(1));
        wr_ptr  = sp[IDX_W-1:0];
    end

    // Purpose: update the stack; a push together with a pop replaces the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
            for (int i = 0; i < NSRC; i++) begin
                slot[i] <= '0;
            end
        end else if (push && pop && sp != '0) begin
            slot[top_ptr] <= push_idx;
        end else if (push) begin
            slot[wr_ptr] <= push_idx;
            sp           <= sp + LVL_W'(1);
        end else if (pop && sp != '0) begin
            sp <= sp - LVL_W'(1);
        end
    end

    // Purpose: the threshold is the top entry, or NSRC when the stack is empty.
    always_comb begin
        if (sp == '0) begin
            cur_level = LVL_W'(NSRC);
        end else begin
            cur_level = {1'b0, slot[top_ptr]};
        end
    end

    // A push onto a full stack must never happen.
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (sp < LVL_W'(NSRC)));

    // A pop from two or more entries lowers the priority, so the level rises.
    assert_pop_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && sp > LVL_W'(1)) |=> (cur_level > $past(cur_level)));

    // A pop on an empty stack leaves it empty.
    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && sp == '0) |=> (sp == '0));

endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: irq_vector_ctrl (top)
// Vectored interrupt controller with NSRC level sources, fixed priority
// (lower index wins), a per-source handler address and a nesting level stack.
// Assumes: the processor holds cpu_ack for one cycle to accept cpu_vec, and
// it signals the end of each handler with a write to address NSRC+1.
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter  int NSRC   = 16,
    parameter  int VEC_W  = 32,
    localparam int ADDR_W = $clog2(NSRC + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_src,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [VEC_W-1:0]  cfg_wdata,
    output logic              cpu_irq,
    output logic [VEC_W-1:0]  cpu_vec,
    input  logic              cpu_ack
);
    localparam int IDX_W = $clog2(NSRC);
    localparam int LVL_W = IDX_W + 1;

    logic [NSRC*VEC_W-1:0] vec_flat;
    logic [NSRC-1:0]       src_en;
    logic                  eos_pulse;
    logic [LVL_W-1:0]      cur_level;
    logic                  found;
    logic [IDX_W-1:0]      winner;
    logic                  push;
    hs_state_t             state;
    logic [IDX_W-1:0]      held_idx;
    logic [VEC_W-1:0]      held_vec;

    irqv_regfile #(
        .NSRC  (NSRC),
        .VEC_W (VEC_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .vec_flat (vec_flat),
        .src_en   (src_en),
        .eos_pulse(eos_pulse)
    );

    irqv_select #(
        .NSRC (NSRC),
        .IDX_W(IDX_W),
        .LVL_W(LVL_W)
    ) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (irq_src),
        .enable(src_en),
        .level (cur_level),
        .found (found),
        .winner(winner)
    );

    irqv_level_stack #(
        .NSRC (NSRC),
        .IDX_W(IDX_W),
        .LVL_W(LVL_W)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_idx (held_idx),
        .pop      (eos_pulse),
        .cur_level(cur_level)
    );

    // Purpose: the handshake completes when a held request is acknowledged.
    always_comb begin
        push = (state == HS_REQ) && cpu_ack;
    end

    // Purpose: capture the winner and hold it unchanged until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= HS_IDLE;
            held_idx <= '0;
            held_vec <= '0;
        end else begin
            case (state)
                HS_IDLE: begin
                    if (found) begin
                        state    <= HS_REQ;
                        held_idx <= winner;
                        held_vec <= vec_flat[winner*VEC_W +: VEC_W];
                    end
                end
                HS_REQ: begin
                    if (cpu_ack) begin
                        state <= HS_IDLE;
                    end
                end
                default: state <= HS_IDLE;
            endcase
        end
    end

    // Purpose: drive the processor-side outputs from the held registers.
    always_comb begin
        cpu_irq = (state == HS_REQ);
        cpu_vec = held_vec;
    end

    // An outstanding request and its address stay put until accepted.
    assert_vec_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && !cpu_ack) |=> (cpu_irq && $stable(cpu_vec)));

    // Acceptance withdraws the request on the same edge.
    assert_ack_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && cpu_ack) |=> !cpu_irq);

    // Each serviced level nests strictly above the one it interrupts.
    assert_strict_nest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ({1'b0, held_idx} < cur_level));

    // An acknowledge without a request leaves the level alone.
    assert_stray_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_irq && cpu_ack && !eos_pulse) |=> $stable(cur_level));

endmodule

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench. The driver pushes expected vectors into a queue, and a
// monitor pops and compares one at each rising cpu_irq. While a request is
// held, the monitor also checks that its vector stays stable.
module test_irq_vector_ctrl;
    localparam int NSRC   = 16;
    localparam int VEC_W  = 32;
    localparam int ADDR_W = $clog2(NSRC + 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src = '0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [VEC_W-1:0]  wdata = '0;
    logic              cpu_irq;
    logic [VEC_W-1:0]  cpu_vec;
    logic              ack = 1'b0;

    int errors = 0;
    int checks = 0;
    logic [VEC_W-1:0] exp_q[$];
    string            tag_q[$];
    logic [VEC_W-1:0] cur_exp = '0;
    string            cur_tag = "";
    logic             prev_irq = 1'b0;
    bit               done = 1'b0;

    always #4 clk = ~clk;

    irq_vector_ctrl #(.NSRC(NSRC), .VEC_W(VEC_W)) i_irq_vector_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_src  (src),
        .cfg_we   (we),
        .cfg_addr (addr),
        .cfg_wdata(wdata),
        .cpu_irq  (cpu_irq),
        .cpu_vec  (cpu_vec),
        .cpu_ack  (ack)
    );

    function automatic logic [VEC_W-1:0] vec_of(int i);
        return 32'hA000_0000 | (i << 8) | 32'h11;
    endfunction

    task automatic expect_req(int i, string tag);
        exp_q.push_back(vec_of(i));
        tag_q.push_back(tag);
    endtask

    task automatic cfg_write(int a, logic [VEC_W-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic eos();
        cfg_write(NSRC + 1, 32'h0);
    endtask

    task automatic check_idle(int cycles, string tag);
        repeat (cycles) @(posedge clk);
        #2;
        checks++;
        if (cpu_irq !== 1'b0) begin
            errors++;
            $display("FAIL %s: cpu_irq actual=%b expected=0", tag, cpu_irq);
        end
    endtask

    task automatic wait_req(string tag);
        bit seen = 1'b0;
        for (int k = 0; k < 20 && !seen; k++) begin
            @(posedge clk); #2;
            if (cpu_irq === 1'b1) seen = 1'b1;
        end
        checks++;
        if (!seen) begin
            errors++;
            $display("FAIL %s: cpu_irq actual=0 expected=1", tag);
        end
    endtask

    // R6: acknowledge and confirm that the request drops on that edge.
    task automatic do_ack(string tag);
        @(negedge clk);
        ack = 1'b1;
        @(posedge clk); #2;
        checks++;
        if (cpu_irq !== 1'b0) begin
            errors++;
            $display("FAIL %s: cpu_irq after ack actual=%b expected=0", tag, cpu_irq);
        end
        @(negedge clk);
        ack = 1'b0;
    endtask

    // Monitor: compare each new request with the queue and check stability.
    always begin
        @(posedge clk); #2;
        if (!rst_n) begin
            prev_irq = 1'b0;
        end else begin
            if (cpu_irq === 1'b1 && !prev_irq) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2: unexpected request vec actual=%h expected=none", cpu_vec);
                end else begin
                    cur_exp = exp_q.pop_front();
                    cur_tag = tag_q.pop_front();
                    if (cpu_vec !== cur_exp) begin
                        errors++;
                        $display("FAIL %s: vec actual=%h expected=%h", cur_tag, cpu_vec, cur_exp);
                    end
                end
            end else if (cpu_irq === 1'b1) begin
                checks++;
                if (cpu_vec !== cur_exp) begin
                    errors++;
                    $display("FAIL R5: held vec actual=%h expected=%h", cpu_vec, cur_exp);
                end
            end
            prev_irq = cpu_irq;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        check_idle(1, "R1 reset");
        src[3] = 1'b1;
        check_idle(3, "R1 disabled after reset");

        for (int i = 0; i < NSRC; i++) cfg_write(i, vec_of(i));
        cfg_write(20, 32'hFFFF_FFFF);               // R9: unmapped address
        check_idle(2, "R9 unmapped write");

        expect_req(3, "R3 first request");
        cfg_write(NSRC, 32'h0000_FFDF);             // all enabled except 5
        wait_req("R3 request raised");
        do_ack("R6 ack 3");
        check_idle(3, "R7 same level held off");

        src[5] = 1'b1; src[7] = 1'b1;
        check_idle(3, "R7/R2 lower or masked held off");

        expect_req(1, "R7 nested request 1");
        src[1] = 1'b1;
        wait_req("R7 nest 1 raised");
        @(negedge clk); src[0] = 1'b1;              // R5: higher arrives mid-handshake
        repeat (4) @(posedge clk);
        expect_req(0, "R7 nested request 0");
        do_ack("R6 ack 1");
        wait_req("R7 nest 0 raised");
        do_ack("R6 ack 0");
        @(negedge clk); src[0] = 1'b0; src[1] = 1'b0;

        eos();
        check_idle(3, "R8 pop to level 1");
        eos();
        check_idle(3, "R8 pop to level 3");
        expect_req(3, "R4 source 3 beats 7");
        eos();
        wait_req("R8 pop to empty");
        do_ack("R6 ack 3 again");
        @(negedge clk); src[3] = 1'b0;
        expect_req(7, "R8 request 7 after pop");
        eos();
        wait_req("R8 source 7 raised");
        do_ack("R6 ack 7");
        @(negedge clk); src[7] = 1'b0;
        eos();
        eos();                                      // R8: pop on empty stack
        check_idle(2, "R8 empty pop");

        @(negedge clk); ack = 1'b1;                 // R10: stray acknowledge
        @(negedge clk); ack = 1'b0;
        check_idle(2, "R10 stray ack");
        expect_req(9, "R10 level unchanged by stray ack");
        src[9] = 1'b1;
        wait_req("R10 source 9 raised");
        do_ack("R6 ack 9");
        @(negedge clk); src[9] = 1'b0;
        eos();

        expect_req(5, "R2 unmasked source 5");
        cfg_write(NSRC, 32'h0000_FFFF);
        wait_req("R2 source 5 raised");
        do_ack("R6 ack 5");
        @(negedge clk); src[5] = 1'b0;
        eos();
        check_idle(3, "R1 quiet at end");

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R3: pending expectations actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule